// File: doc/BRIEF.md
# Linked-Load Register and Store-Conditional Packet Issuer

This unit sits on the processor side of a first-level cache controller. It provides linked-load and store-conditional semantics without ever placing a reservation on the network. A linked load is sent out as an ordinary read. The unit then keeps the returned value, together with its address and access width, in one local register. A store-conditional that matches this register is turned into a packet that carries the remembered value and the new value. The memory side can then decide success by comparing the contents. The unit relays the boolean verdict of the memory side back to the processor.

The register survives coherence traffic. Invalidations and updates of the line reach the cache arrays, which lie outside this unit, and they leave the register untouched. A repeated linked load to the held address still reads the current value for a local spin, but it does not overwrite the remembered value. Every store-conditional consumes the register. One that cannot match fails at once and sends nothing.

Top module: `llsc_unit`

## Requirements
- R1: After reset the register is empty: `req_ready` is 1, `rsp_valid`, `rd_valid` and `flit_valid` are 0, and a store-conditional issued first returns `rsp_sc_ok`=0 with no flit sent.
- R2: A linked load (`req_is_sc`=0) that does not hit the register issues exactly one read on the `rd_*` port with the request address and width. It returns the read data on `rsp_data` with a one-cycle `rsp_valid`, and records address, data and width.
- R3: A linked load to the address held in a valid register still issues a read and returns the fresh data, but the register keeps the value captured earlier. A later matching store-conditional carries that earlier value.
- R4: A linked load to a different address replaces the register contents, so a store-conditional to the old address fails.
- R5: A matching narrow store-conditional (`req_long`=0) emits 2 flits of `WORD_W` bits: the low word of the held value first, then the low word of the write data. `flit_last` is set on the second flit.
- R6: A matching wide store-conditional (`req_long`=1) emits 4 flits: held value low word, held value high word, write data low word, write data high word. `flit_last` is set on the fourth flit.
- R7: A store-conditional with the register empty or with a different address returns `rsp_sc_ok`=0 in the cycle after acceptance, emits no flit and issues no read.
- R8: A store-conditional whose `req_long` differs from the recorded width fails locally as in R7.
- R9: Every store-conditional empties the register, so an immediately repeated one fails locally.
- R10: Coherence messages (`coh_valid` with any `coh_addr`) do not alter the register: a matching store-conditional still goes out with the value held before the messages.
- R11: While `flit_valid` is 1 and `flit_ready` is 0, the flit stays presented with unchanged `flit_data`.
- R12: After its packet, a store-conditional waits for `sc_reply_valid` and returns `sc_reply_ok` on `rsp_sc_ok`. The read port is used only by linked loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Unit idle and accepting a request |
| req_is_sc | input | 1 | 1 store-conditional, 0 linked load |
| req_long | input | 1 | 1 wide (two words), 0 narrow (one word) |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | 2*WORD_W | Store-conditional write data |
| rsp_valid | output | 1 | One-cycle processor response |
| rsp_data | output | 2*WORD_W | Linked-load data (0 for store-conditional) |
| rsp_sc_ok | output | 1 | Store-conditional verdict |
| rd_valid | output | 1 | Read request to the memory side |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | ADDR_W | Read address |
| rd_long | output | 1 | Read width |
| rd_rsp_valid | input | 1 | Read data returned |
| rd_rsp_data | input | 2*WORD_W | Returned read data |
| flit_valid | output | 1 | Store-conditional flit presented |
| flit_ready | input | 1 | Flit accepted |
| flit_data | output | WORD_W | Flit payload |
| flit_last | output | 1 | Final flit of the packet |
| sc_addr | output | ADDR_W | Address of the packet in flight |
| sc_long | output | 1 | Width of the packet in flight |
| sc_reply_valid | input | 1 | Memory verdict present |
| sc_reply_ok | input | 1 | Memory verdict |
| coh_valid | input | 1 | Coherence invalidate/update seen |
| coh_addr | input | ADDR_W | Coherence target address |

## Verification
Store-conditionals are tried after an empty register, after a matching load, after a load to another address, with a mismatched width, and repeated twice in a row. The flit count and the verdict tell a local failure from a packet. The repeated load with changed memory data and the coherence pulses separate keeping the first value from reloading it, because the old-value flits of the following packet differ in the two cases. Narrow and wide packets under alternating flit backpressure check flit order, the `flit_last` position and stability while stalled.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD,
      ST_WAIT,
      ST_SEND,
      ST_REPLY,
      ST_RSP
   } llsc_state_e;
endpackage

// File: rtl/llsc_reg.sv
module llsc_reg #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [DATA_W-1:0] ld_data,
   input  logic              ld_long,
   input  logic              clr,
   output logic              hold_valid,
   output logic [ADDR_W-1:0] hold_addr,
   output logic [DATA_W-1:0] hold_data,
   output logic              hold_long
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_valid <= 1'b0;
         hold_addr  <= '0;
         hold_data  <= '0;
         hold_long  <= 1'b0;
      end else if (load) begin
         hold_valid <= 1'b1;
         hold_addr  <= ld_addr;
         hold_data  <= ld_data;
         hold_long  <= ld_long;
      end else if (clr) begin
         hold_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/llsc_flitgen.sv
module llsc_flitgen #(
   parameter int WORD_W = 32,
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              wide,
   input  logic [DATA_W-1:0] old_d,
   input  logic [DATA_W-1:0] new_d,
   input  logic              ready,
   output logic              valid,
   output logic [WORD_W-1:0] data,
   output logic              last,
   output logic              done
);
   localparam int WPD = DATA_W / WORD_W;
   localparam int NF  = 2 * WPD;
   localparam int CW  = $clog2(NF);

   generate
      if (DATA_W % WORD_W != 0 || WPD < 1)
         $error("llsc_flitgen: DATA_W must be a multiple of WORD_W");
   endgenerate

   logic [WORD_W-1:0] wide_w [NF];
   logic [CW-1:0]     idx;
   logic [CW-1:0]     last_idx;

   generate
      for (genvar i = 0; i < NF; i++) begin : g_word
         if (i < WPD) begin : g_old
            assign wide_w[i] = old_d[i*WORD_W +: WORD_W];
         end else begin : g_new
            assign wide_w[i] = new_d[(i-WPD)*WORD_W +: WORD_W];
         end
      end
   endgenerate

   assign last_idx = wide ? CW'(NF-1) : CW'(1);
   assign valid    = active;
   assign last     = (idx == last_idx);
   assign done     = valid && ready && last;

   always_comb begin
      if (wide)
         data = wide_w[idx];
      else if (idx == '0)
         data = old_d[WORD_W-1:0];
      else
         data = new_d[WORD_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         idx <= '0;
      else if (done)
         idx <= '0;
      else if (valid && ready)
         idx <= idx + CW'(1);
   end

   // R11
   flit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid && !ready |=> valid && $stable(data));
endmodule

// File: rtl/llsc_ctrl.sv
module llsc_ctrl
   import llsc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_is_sc,
   input  logic              req_long,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rsp_sc_ok,
   output logic              rd_valid,
   input  logic              rd_ready,
   input  logic              rd_rsp_valid,
   input  logic              sc_reply_valid,
   input  logic              sc_reply_ok,
   input  logic [DATA_W-1:0] rd_rsp_data,
   input  logic              hold_valid,
   input  logic [ADDR_W-1:0] hold_addr,
   input  logic              hold_long,
   output logic              reg_load,
   output logic              reg_clr,
   output logic              fg_active,
   input  logic              fg_done,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              cur_long,
   output logic [DATA_W-1:0] cur_wdata
);
   llsc_state_e       state;
   logic              cur_is_sc;
   logic              spin;
   logic [DATA_W-1:0] rsp_d;
   logic              rsp_ok;
   logic              req_fire;
   logic              sc_hit;

   assign req_fire = req_valid && (state == ST_IDLE);
   assign sc_hit   = hold_valid && (hold_addr == req_addr) && (hold_long == req_long);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cur_is_sc <= 1'b0;
         cur_long  <= 1'b0;
         cur_addr  <= '0;
         cur_wdata <= '0;
         spin      <= 1'b0;
         rsp_d     <= '0;
         rsp_ok    <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: if (req_fire) begin
               cur_is_sc <= req_is_sc;
               cur_long  <= req_long;
               cur_addr  <= req_addr;
               cur_wdata <= req_wdata;
               rsp_d     <= '0;
               rsp_ok    <= 1'b0;
               if (req_is_sc) begin
                  state <= sc_hit ? ST_SEND : ST_RSP;
               end else begin
                  spin  <= hold_valid && (hold_addr == req_addr);
                  state <= ST_RD;
               end
            end
            ST_RD:    if (rd_ready) state <= ST_WAIT;
            ST_WAIT:  if (rd_rsp_valid) begin
               rsp_d <= rd_rsp_data;
               state <= ST_RSP;
            end
            ST_SEND:  if (fg_done) state <= ST_REPLY;
            ST_REPLY: if (sc_reply_valid) begin
               rsp_ok <= sc_reply_ok;
               state  <= ST_RSP;
            end
            ST_RSP:   state <= ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (state == ST_IDLE);
   assign rd_valid  = (state == ST_RD);
   assign reg_load  = (state == ST_WAIT) && rd_rsp_valid && !spin;
   assign reg_clr   = req_fire && req_is_sc;
   assign fg_active = (state == ST_SEND);
   assign rsp_valid = (state == ST_RSP);
   assign rsp_data  = rsp_d;
   assign rsp_sc_ok = rsp_ok;

   // R7 R8
   sc_local_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_fire && req_is_sc && !sc_hit |=> rsp_valid && !rsp_sc_ok && !fg_active);

   // R9
   sc_consumes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_clr |=> !hold_valid);

   // R12
   rd_only_ll_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> !cur_is_sc);

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !rsp_valid && !rd_valid && !fg_active);
endmodule

// File: rtl/llsc_unit.sv
module llsc_unit #(
   parameter int ADDR_W = 32,
   parameter int WORD_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic                  req_is_sc,
   input  logic                  req_long,
   input  logic [ADDR_W-1:0]     req_addr,
   input  logic [2*WORD_W-1:0]   req_wdata,
   output logic                  rsp_valid,
   output logic [2*WORD_W-1:0]   rsp_data,
   output logic                  rsp_sc_ok,
   output logic                  rd_valid,
   input  logic                  rd_ready,
   output logic [ADDR_W-1:0]     rd_addr,
   output logic                  rd_long,
   input  logic                  rd_rsp_valid,
   input  logic [2*WORD_W-1:0]   rd_rsp_data,
   output logic                  flit_valid,
   input  logic                  flit_ready,
   output logic [WORD_W-1:0]     flit_data,
   output logic                  flit_last,
   output logic [ADDR_W-1:0]     sc_addr,
   output logic                  sc_long,
   input  logic                  sc_reply_valid,
   input  logic                  sc_reply_ok,
   input  logic                  coh_valid,
   input  logic [ADDR_W-1:0]     coh_addr
);
   localparam int DATA_W = 2 * WORD_W;

   generate
      if (ADDR_W < 1 || WORD_W < 1)
         $error("llsc_unit: widths must be positive");
   endgenerate

   logic              hold_valid, hold_long;
   logic [ADDR_W-1:0] hold_addr;
   logic [DATA_W-1:0] hold_data;
   logic              reg_load, reg_clr, fg_active, fg_done;
   logic [ADDR_W-1:0] cur_addr;
   logic              cur_long;
   logic [DATA_W-1:0] cur_wdata;

   llsc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
      .clk, .rst_n, .req_valid, .req_ready, .req_is_sc, .req_long, .req_addr,
      .req_wdata, .rsp_valid, .rsp_data, .rsp_sc_ok, .rd_valid, .rd_ready,
      .rd_rsp_valid, .sc_reply_valid, .sc_reply_ok, .rd_rsp_data,
      .hold_valid, .hold_addr, .hold_long, .reg_load, .reg_clr, .fg_active,
      .fg_done, .cur_addr, .cur_long, .cur_wdata
   );

   llsc_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_reg (
      .clk, .rst_n, .load(reg_load), .ld_addr(cur_addr), .ld_data(rd_rsp_data),
      .ld_long(cur_long), .clr(reg_clr), .hold_valid, .hold_addr, .hold_data,
      .hold_long
   );

   llsc_flitgen #(.WORD_W(WORD_W), .DATA_W(DATA_W)) u_flit (
      .clk, .rst_n, .active(fg_active), .wide(cur_long), .old_d(hold_data),
      .new_d(cur_wdata), .ready(flit_ready), .valid(flit_valid),
      .data(flit_data), .last(flit_last), .done(fg_done)
   );

   assign rd_addr = cur_addr;
   assign rd_long = cur_long;
   assign sc_addr = cur_addr;
   assign sc_long = cur_long;

   // R10
   coh_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      coh_valid && hold_valid && (coh_addr == hold_addr) && !reg_clr && !reg_load
      |=> hold_valid && $stable(hold_data));

   // R5 R6
   flit_only_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flit_valid) |-> $past(reg_clr));
endmodule

// File: tb/llsc_unit_bench.sv
module llsc_unit_bench;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int WW = 32;
   localparam int DW = 2 * WW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_is_sc = 1'b0, req_long = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic req_ready, rsp_valid, rsp_sc_ok;
   logic [DW-1:0] rsp_data;
   logic rd_valid, rd_long;
   logic rd_ready = 1'b1;
   logic [AW-1:0] rd_addr;
   logic rd_rsp_valid = 1'b0;
   logic [DW-1:0] rd_rsp_data = '0;
   logic flit_valid, flit_last;
   logic flit_ready = 1'b1;
   logic [WW-1:0] flit_data;
   logic [AW-1:0] sc_addr;
   logic sc_long;
   logic sc_reply_valid = 1'b0, sc_reply_ok = 1'b0;
   logic coh_valid = 1'b0;
   logic [AW-1:0] coh_addr = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   llsc_unit #(.ADDR_W(AW), .WORD_W(WW)) u_llsc_unit (
      .clk, .rst_n, .req_valid, .req_ready, .req_is_sc, .req_long, .req_addr,
      .req_wdata, .rsp_valid, .rsp_data, .rsp_sc_ok, .rd_valid, .rd_ready,
      .rd_addr, .rd_long, .rd_rsp_valid, .rd_rsp_data, .flit_valid,
      .flit_ready, .flit_data, .flit_last, .sc_addr, .sc_long,
      .sc_reply_valid, .sc_reply_ok, .coh_valid, .coh_addr
   );

   int n_chk = 0, n_bad = 0;
   string cur_tag = "R1";

   // reference model of the held register
   logic          m_valid = 1'b0, m_long = 1'b0;
   logic [AW-1:0] m_addr = '0;
   logic [DW-1:0] m_data = '0;

   logic [WW-1:0] exp_flits[$];
   logic [AW-1:0] exp_rd_addr;
   logic          exp_rd_long;
   logic [DW-1:0] mem_next = '0;
   logic          reply_val = 1'b0;
   logic          bp_on = 1'b0;
   int flits_seen = 0, rd_seen = 0;
   int cyc = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // memory side, flit sink, backpressure and watchdog
   int rd_stage = 0, rp_stage = 0;
   logic prev_stall = 1'b0;
   logic [WW-1:0] prev_data = '0;
   always @(negedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
      if (rd_stage == 1) begin
         rd_rsp_valid = 1'b1; rd_rsp_data = mem_next; rd_stage = 2;
      end else if (rd_stage == 2) begin
         rd_rsp_valid = 1'b0; rd_stage = 0;
      end
      if (rp_stage == 1) begin
         sc_reply_valid = 1'b1; sc_reply_ok = reply_val; rp_stage = 2;
      end else if (rp_stage == 2) begin
         sc_reply_valid = 1'b0; rp_stage = 0;
      end
      if (rst_n && rd_valid && rd_ready) begin
         rd_seen++;
         chk(rd_addr == exp_rd_addr, cur_tag, "rd_addr", 64'(rd_addr), 64'(exp_rd_addr));
         chk(rd_long == exp_rd_long, cur_tag, "rd_long", 64'(rd_long), 64'(exp_rd_long));
         rd_stage = 1;
      end
      if (rst_n && prev_stall)
         chk(flit_valid && flit_data == prev_data, "R11", "stalled flit",
             64'(flit_data), 64'(prev_data));
      flit_ready = bp_on ? cyc[0] : 1'b1;
      prev_stall = flit_valid && !flit_ready;
      prev_data  = flit_data;
      if (rst_n && flit_valid && flit_ready) begin
         logic [WW-1:0] e;
         flits_seen++;
         if (exp_flits.size() == 0) begin
            chk(1'b0, cur_tag, "unexpected flit", 64'(flit_data), 64'(0));
         end else begin
            e = exp_flits.pop_front();
            chk(flit_data == e, cur_tag, "flit_data", 64'(flit_data), 64'(e));
            chk(flit_last == (exp_flits.size() == 0), cur_tag, "flit_last",
                64'(flit_last), 64'(exp_flits.size() == 0));
         end
         if (flit_last) rp_stage = 1;
      end
   end

   task automatic send_req(input bit is_sc, input bit lng, input logic [AW-1:0] a,
                           input logic [DW-1:0] wd);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_is_sc = is_sc; req_long = lng;
      req_addr = a; req_wdata = wd;
      forever begin
         @(negedge clk);
         req_valid = 1'b0;
         #1;
         if (rsp_valid) break;
      end
   endtask

   task automatic do_ll(input string tag, input logic [AW-1:0] a, input bit lng,
                        input logic [DW-1:0] md);
      cur_tag = tag; flits_seen = 0; rd_seen = 0;
      exp_rd_addr = a; exp_rd_long = lng; mem_next = md;
      send_req(1'b0, lng, a, '0);
      chk(rsp_data == md, tag, "ll rsp_data", rsp_data, md);
      chk(rd_seen == 1 && flits_seen == 0, tag, "ll traffic",
          64'(rd_seen), 64'(1));
      if (!(m_valid && m_addr == a)) begin
         m_valid = 1'b1; m_addr = a; m_data = md; m_long = lng;
      end
   endtask

   task automatic do_sc(input string tag, input logic [AW-1:0] a, input bit lng,
                        input logic [DW-1:0] wd, input bit rep);
      bit hit;
      int nf;
      cur_tag = tag; flits_seen = 0; rd_seen = 0; reply_val = rep;
      hit = m_valid && m_addr == a && m_long == lng;
      exp_flits.delete();
      if (hit) begin
         if (lng) begin
            exp_flits.push_back(m_data[WW-1:0]);  exp_flits.push_back(m_data[DW-1:WW]);
            exp_flits.push_back(wd[WW-1:0]);      exp_flits.push_back(wd[DW-1:WW]);
         end else begin
            exp_flits.push_back(m_data[WW-1:0]);  exp_flits.push_back(wd[WW-1:0]);
         end
      end
      nf = hit ? (lng ? 4 : 2) : 0;
      send_req(1'b1, lng, a, wd);
      chk(rsp_sc_ok == (hit && rep), tag, "sc verdict", 64'(rsp_sc_ok), 64'(hit && rep));
      chk(flits_seen == nf && rd_seen == 0, tag, "sc flit count",
          64'(flits_seen), 64'(nf));
      m_valid = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk(req_ready && !rsp_valid && !rd_valid && !flit_valid, "R1", "idle outputs",
          {60'd0, req_ready, rsp_valid, rd_valid, flit_valid}, 64'h8);
      do_sc("R1", 32'h100, 1'b0, 64'h5, 1'b1);
      // R2 narrow load then R5 narrow packet, R12 verdict relay
      do_ll("R2", 32'h100, 1'b0, 64'h1111_2222_3333_4444);
      do_sc("R5", 32'h100, 1'b0, 64'hAAAA_BBBB_CCCC_DDDD, 1'b1);
      // R9 repeated SC fails
      do_sc("R9", 32'h100, 1'b0, 64'h1, 1'b1);
      // R3 spin keeps first value; R10 coherence; R6 wide packet; R11 backpressure
      do_ll("R2", 32'h200, 1'b1, 64'h0123_4567_89AB_CDEF);
      do_ll("R3", 32'h200, 1'b1, 64'hFEDC_BA98_7654_3210);
      @(negedge clk); coh_valid = 1'b1; coh_addr = 32'h200;
      @(negedge clk); coh_addr = 32'h300;
      @(negedge clk); coh_valid = 1'b0;
      bp_on = 1'b1;
      do_sc("R10", 32'h200, 1'b1, 64'h5555_6666_7777_8888, 1'b0);
      // R4 replacement, R7 mismatch
      do_ll("R4", 32'h400, 1'b0, 64'h9);
      do_ll("R4", 32'h500, 1'b0, 64'hA);
      do_sc("R7", 32'h400, 1'b0, 64'hB, 1'b1);
      // R8 width mismatch
      do_ll("R8", 32'h500, 1'b0, 64'hC);
      do_sc("R8", 32'h500, 1'b1, 64'hD, 1'b1);
      // R6 wide success under backpressure
      do_ll("R6", 32'h600, 1'b1, 64'hDEAD_BEEF_CAFE_F00D);
      do_sc("R6", 32'h600, 1'b1, 64'h0BAD_F00D_1234_5678, 1'b1);
      bp_on = 1'b0;
      // R12 failing verdict relayed on a narrow hit
      do_ll("R12", 32'h700, 1'b0, 64'h77);
      do_sc("R12", 32'h700, 1'b0, 64'h88, 1'b0);
      repeat (2) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule